// File: doc/BRIEF.md
# Multi-Slot Local Bus Address Decoder

This block sits behind the local side of a PCI carrier that hosts four plug-in module slots. Each local access arrives with a window select, a byte-or-halfword size, an address and write data. The block turns it into a request for a single slot. The request names the slot, a sub-space code, an offset within that sub-space, the data, and a one-cycle strobe. The addressed slot's read data comes back on the response port one cycle later.

There are three windows, each split evenly among the slots. The register window gives each slot 256 bytes, divided into I/O, ID and interrupt sub-spaces. The halfword memory window gives each slot 8 MiB, and the byte memory window gives each slot 4 MiB. Three mode bits sit in a small configuration byte space and select big-endian handling. One bit applies to the register window and one to the halfword memory window. The third is kept for the carrier's control-register logic, which lies outside this block. The byte memory window is never adjusted.

Requests to a slot that is not fitted, or to an unused code, still complete. Writes are dropped and reads return zero.

Top module: `lbr_slot_router`

## Requirements
- R1: Register window (acc_win=0). The slot is address bits [9:8] and the sub-space code is bits [7:6]. Code 0 is I/O, with offset = address & 0x7F and slot_space=0. Code 2 is ID, with offset = address & 0x3F and slot_space=2. Code 3 is interrupt, with offset = address & 0x3F and slot_space=3.
- R2: In the register window, sub-space code 1 raises no strobe. The access still completes, and a read returns 0.
- R3: Halfword memory window (acc_win=1). The slot is address bits [24:23], the offset is bits [22:0], and slot_space=4.
- R4: Byte memory window (acc_win=2). The slot is address bits [23:22], the offset is bits [21:0], and slot_space=5. Bit 24 is ignored, and no endian adjustment is ever applied.
- R5: In big-endian mode, a byte access (acc_wide=0) to the register or halfword window inverts address bit 0 before any decoding.
- R6: In big-endian mode, a halfword access to the register or halfword window has its two bytes swapped, toward the slot on writes and back on reads. Byte writes pass data through unchanged. A byte read returns the slot's low byte, zero-extended.
- R7: The mode bits live at configuration offsets 0x2B, 0x2F and 0x33, in bit 0 of each byte. 0x2B drives ctrl_big_endian, 0x2F controls the register window, and 0x33 controls the halfword window. Each bit reads back as written, and every other read bit is 0. Any other offset reads 0, and writes to it change nothing.
- R8: An access to a slot whose slot_present bit is 0 raises no strobe. It completes, and a read returns 0.
- R9: A strobe appears on exactly one slot_req bit, in the cycle after acc_valid is sampled, and lasts one cycle. acc_done pulses one cycle after that, with acc_rdata. A write returns 0.
- R10: During and after reset, no strobe and no acc_done are asserted, and all mode bits are 0.
- R11: acc_win=3 selects nothing. The access completes, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte (combinational) |
| ctrl_big_endian | output | 1 | Mode bit for the carrier control-register window |
| acc_valid | input | 1 | Local access request, one cycle |
| acc_win | input | 2 | Window: 0 register, 1 halfword memory, 2 byte memory, 3 none |
| acc_write | input | 1 | 1 = write |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| acc_addr | input | 25 | Window-relative byte address |
| acc_wdata | input | 16 | Write data |
| acc_done | output | 1 | Completion pulse |
| acc_rdata | output | 16 | Read data, valid with acc_done |
| slot_present | input | 4 | Slot fitted flags |
| slot_req | output | 4 | One-hot per-slot strobe |
| slot_write | output | 1 | Request is a write |
| slot_wide | output | 1 | Request is 16-bit |
| slot_space | output | 3 | Sub-space code |
| slot_offset | output | 23 | Offset within the sub-space |
| slot_wdata | output | 16 | Write data after endian adjustment |
| slot_rdata | input | 64 | Read data, 16 bits per slot, slot 0 lowest |

## Verification
The assertions check several properties on every cycle. The strobe vector is never more than one-hot, and a strobe never lands on an empty slot. Every strobe is followed by a completion. I/O offsets stay below 128, ID and interrupt offsets below 64, and byte-window offsets below 4 MiB. A mode-bit write is always visible on the following cycle.

Other properties can only be shown by the bench's sweeps. These sweeps cover every window, slot, sub-space code, size, direction and endian mode. They show that the right slot and offset are chosen at all, that the address bit flips only for byte accesses, that halfword data is swapped in both directions, and that absent slots and unused codes read back zero.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    localparam int SLOT_W       = 2;
    localparam int NUM_SLOTS    = 1 << SLOT_W;
    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 25;
    localparam int M16_OFF_W    = 23;
    localparam int M8_OFF_W     = 22;
    localparam int OFF_W        = M16_OFF_W;
    localparam int REG_SLOT_LSB = 8;
    localparam int SUB_LSB      = 6;
    localparam int IO_OFF_W     = 7;
    localparam int IDINT_OFF_W  = 6;
    localparam int CFG_AW       = 8;
    localparam int CFG_DW       = 8;
    localparam int NUM_MODES    = 3;
    localparam logic [CFG_AW-1:0] MODE_BASE   = 8'h2B;
    localparam int                MODE_STRIDE = 4;

    typedef enum logic [1:0] {
        WIN_REG  = 2'd0,
        WIN_M16  = 2'd1,
        WIN_M8   = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO   = 3'd0,
        SP_NONE = 3'd1,
        SP_ID   = 3'd2,
        SP_INT  = 3'd3,
        SP_M16  = 3'd4,
        SP_M8   = 3'd5
    } space_e;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFF_W-1:0]  offset;
    } dec_t;

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] d);
        return {d[DATA_W/2-1:0], d[DATA_W-1:DATA_W/2]};
    endfunction

    function automatic logic [CFG_AW-1:0] mode_offset(input int idx);
        return MODE_BASE + CFG_AW'(idx * MODE_STRIDE);
    endfunction
endpackage

// File: rtl/lbr_cfg_regs.sv
module lbr_cfg_regs
    import lbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    output logic [CFG_DW-1:0]    cfg_rdata,
    output logic [NUM_MODES-1:0] mode_be
);
    logic [NUM_MODES-1:0] hit;
    logic                 unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[CFG_DW-1:1];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        assign hit[g] = (cfg_addr == mode_offset(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_be[g] <= 1'b0;
            end else if (cfg_we && hit[g]) begin
                mode_be[g] <= cfg_wdata[0];
            end
        end

        // R7
        mode_wr_vis_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(cfg_we) && $past(hit[g]) && !$past(rst)) |-> (mode_be[g] == $past(cfg_wdata[0])));
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_MODES; i++) begin
            if (hit[i]) cfg_rdata[0] = mode_be[i];
        end
    end
endmodule

// File: rtl/lbr_endian_adj.sv
module lbr_endian_adj
    import lbr_pkg::*;
(
    input  win_e              win,
    input  logic              wide,
    input  logic              be_reg,
    input  logic              be_m16,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              swap
);
    logic be_sel;

    always_comb begin
        unique case (win)
            WIN_REG: be_sel = be_reg;
            WIN_M16: be_sel = be_m16;
            default: be_sel = 1'b0;
        endcase
    end

    assign swap     = be_sel & wide;
    assign addr_out = addr_in ^ {{(ADDR_W-1){1'b0}}, be_sel & ~wide};
endmodule

// File: rtl/lbr_addr_decode.sv
module lbr_addr_decode
    import lbr_pkg::*;
(
    input  win_e              win,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec       = '0;
        dec.space = SP_NONE;
        unique case (win)
            WIN_REG: begin
                dec.slot = addr[REG_SLOT_LSB +: SLOT_W];
                unique case (addr[SUB_LSB +: 2])
                    2'd0: begin
                        dec.ok     = 1'b1;
                        dec.space  = SP_IO;
                        dec.offset = OFF_W'(addr[IO_OFF_W-1:0]);
                    end
                    2'd2: begin
                        dec.ok     = 1'b1;
                        dec.space  = SP_ID;
                        dec.offset = OFF_W'(addr[IDINT_OFF_W-1:0]);
                    end
                    2'd3: begin
                        dec.ok     = 1'b1;
                        dec.space  = SP_INT;
                        dec.offset = OFF_W'(addr[IDINT_OFF_W-1:0]);
                    end
                    default: ;
                endcase
            end
            WIN_M16: begin
                dec.ok     = 1'b1;
                dec.slot   = addr[M16_OFF_W +: SLOT_W];
                dec.space  = SP_M16;
                dec.offset = OFF_W'(addr[M16_OFF_W-1:0]);
            end
            WIN_M8: begin
                dec.ok     = 1'b1;
                dec.slot   = addr[M8_OFF_W +: SLOT_W];
                dec.space  = SP_M8;
                dec.offset = OFF_W'(addr[M8_OFF_W-1:0]);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbr_slot_router.sv
module lbr_slot_router
    import lbr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [CFG_DW-1:0]           cfg_wdata,
    output logic [CFG_DW-1:0]           cfg_rdata,
    output logic                        ctrl_big_endian,
    input  logic                        acc_valid,
    input  logic [1:0]                  acc_win,
    input  logic                        acc_write,
    input  logic                        acc_wide,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [DATA_W-1:0]           acc_wdata,
    output logic                        acc_done,
    output logic [DATA_W-1:0]           acc_rdata,
    input  logic [NUM_SLOTS-1:0]        slot_present,
    output logic [NUM_SLOTS-1:0]        slot_req,
    output logic                        slot_write,
    output logic                        slot_wide,
    output logic [2:0]                  slot_space,
    output logic [OFF_W-1:0]            slot_offset,
    output logic [DATA_W-1:0]           slot_wdata,
    input  logic [NUM_SLOTS*DATA_W-1:0] slot_rdata
);
    win_e                 win_in;
    logic [NUM_MODES-1:0] mode_be;
    logic [ADDR_W-1:0]    addr_eff;
    logic                 swap;
    dec_t                 dec;
    logic [NUM_SLOTS-1:0] strobe_d;
    logic [DATA_W-1:0]    rd_arr [NUM_SLOTS];
    logic                 pend_q, hit_q, swap_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [DATA_W-1:0]    rd_sel, rd_next;

    assign win_in          = win_e'(acc_win);
    assign ctrl_big_endian = mode_be[0];

    lbr_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mode_be   (mode_be)
    );

    lbr_endian_adj u_endian (
        .win      (win_in),
        .wide     (acc_wide),
        .be_reg   (mode_be[1]),
        .be_m16   (mode_be[2]),
        .addr_in  (acc_addr),
        .addr_out (addr_eff),
        .swap     (swap)
    );

    lbr_addr_decode u_dec (
        .win  (win_in),
        .addr (addr_eff),
        .dec  (dec)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign strobe_d[g] = acc_valid && dec.ok && (dec.slot == SLOT_W'(g)) && slot_present[g];
        assign rd_arr[g]   = slot_rdata[g*DATA_W +: DATA_W];
    end

    assign rd_sel = rd_arr[slot_q];

    always_comb begin
        if (!pend_q || !hit_q || slot_write) begin
            rd_next = '0;
        end else if (slot_wide) begin
            rd_next = swap_q ? swap_bytes(rd_sel) : rd_sel;
        end else begin
            rd_next = {{(DATA_W/2){1'b0}}, rd_sel[DATA_W/2-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_req    <= '0;
            pend_q      <= 1'b0;
            hit_q       <= 1'b0;
            swap_q      <= 1'b0;
            slot_q      <= '0;
            slot_write  <= 1'b0;
            slot_wide   <= 1'b0;
            slot_space  <= SP_NONE;
            slot_offset <= '0;
            slot_wdata  <= '0;
            acc_done    <= 1'b0;
            acc_rdata   <= '0;
        end else begin
            slot_req  <= strobe_d;
            pend_q    <= acc_valid;
            hit_q     <= |strobe_d;
            acc_done  <= pend_q;
            acc_rdata <= rd_next;
            if (acc_valid) begin
                slot_q      <= dec.slot;
                swap_q      <= swap;
                slot_write  <= acc_write;
                slot_wide   <= acc_wide;
                slot_space  <= dec.space;
                slot_offset <= dec.offset;
                slot_wdata  <= swap ? swap_bytes(acc_wdata) : acc_wdata;
            end
        end
    end

    // R9
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_req));

    // R9
    req_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|slot_req) |=> acc_done);

    // R8
    req_fitted_chk: assert property (@(posedge clk) disable iff (rst)
        ((slot_req & ~slot_present) == '0));

    // R1
    io_off_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((|slot_req) && slot_space == SP_IO) |-> (slot_offset < OFF_W'(1 << IO_OFF_W)));

    // R1
    idint_off_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((|slot_req) && (slot_space == SP_ID || slot_space == SP_INT))
            |-> (slot_offset < OFF_W'(1 << IDINT_OFF_W)));

    // R4
    m8_off_range_chk: assert property (@(posedge clk) disable iff (rst)
        ((|slot_req) && slot_space == SP_M8) |-> (slot_offset < OFF_W'(1 << M8_OFF_W)));
endmodule

// File: tb/sim_lbr_slot_router.sv
`timescale 1ns/1ps
module sim_lbr_slot_router;
    import lbr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        ctrl_big_endian;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_win = '0;
    logic        acc_write = 1'b0;
    logic        acc_wide = 1'b0;
    logic [24:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_done;
    logic [15:0] acc_rdata;
    logic [3:0]  slot_present = 4'b1111;
    logic [3:0]  slot_req;
    logic        slot_write, slot_wide;
    logic [2:0]  slot_space;
    logic [22:0] slot_offset;
    logic [15:0] slot_wdata;
    logic [63:0] slot_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [15:0] slot_val(input int i);
        return 16'h1A2B + 16'(i) * 16'h1111;
    endfunction

    assign slot_rdata = {slot_val(3), slot_val(2), slot_val(1), slot_val(0)};

    lbr_slot_router u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl_big_endian(ctrl_big_endian),
        .acc_valid(acc_valid), .acc_win(acc_win), .acc_write(acc_write), .acc_wide(acc_wide),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .slot_present(slot_present), .slot_req(slot_req), .slot_write(slot_write),
        .slot_wide(slot_wide), .slot_space(slot_space), .slot_offset(slot_offset),
        .slot_wdata(slot_wdata), .slot_rdata(slot_rdata)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        cfg_addr = a;
        #1;
        check(req, "cfg_rdata", 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic do_access(input int win, input bit wr, input bit wide,
                             input logic [24:0] addr, input bit be);
        logic [24:0] ea;
        logic [15:0] wd, exp_wd, exp_rd, v;
        logic [22:0] exp_off;
        int          es, sp, code;
        bit          ok, sw;
        logic [3:0]  exp_req;
        string       tag;

        wd = 16'hC35A ^ addr[15:0];
        ea = (be && !wide && win < 2) ? (addr ^ 25'd1) : addr;
        sw = be && wide && win < 2;
        ok = 1'b0; es = 0; sp = 1; exp_off = '0; code = 0;
        case (win)
            0: begin
                es = int'(ea[9:8]); code = int'(ea[7:6]);
                ok = (code != 1); sp = code;
                exp_off = (code == 0) ? 23'(ea[6:0]) : 23'(ea[5:0]);
            end
            1: begin es = int'(ea[24:23]); ok = 1'b1; sp = 4; exp_off = ea[22:0]; end
            2: begin es = int'(ea[23:22]); ok = 1'b1; sp = 5; exp_off = 23'(ea[21:0]); end
            default: ;
        endcase
        exp_req = (ok && slot_present[es]) ? (4'b0001 << es) : 4'b0000;

        if (win == 3)                          tag = "R11";
        else if (ok && !slot_present[es])      tag = "R8";
        else if (win == 0 && code == 1)        tag = "R2";
        else if (win == 2)                     tag = "R4";
        else if (be && !wide)                  tag = "R5";
        else if (be && wide)                   tag = "R6";
        else if (win == 1)                     tag = "R3";
        else                                   tag = "R1";

        acc_valid = 1'b1; acc_win = 2'(win); acc_write = wr; acc_wide = wide;
        acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        check(tag, "slot_req", 32'(slot_req), 32'(exp_req));
        if (exp_req != 0) begin
            exp_wd = sw ? {wd[7:0], wd[15:8]} : wd;
            check(tag, "slot_space", 32'(slot_space), 32'(sp));
            check(tag, "slot_offset", 32'(slot_offset), 32'(exp_off));
            check(tag, "slot_write", 32'(slot_write), 32'(wr));
            check(tag, "slot_wide", 32'(slot_wide), 32'(wide));
            if (wr) check(sw ? "R6" : tag, "slot_wdata", 32'(slot_wdata), 32'(exp_wd));
        end
        @(negedge clk);
        check("R9", "slot_req after pulse", 32'(slot_req), 32'(0));
        check("R9", "acc_done", 32'(acc_done), 32'(1));
        exp_rd = '0;
        if (exp_req != 0 && !wr) begin
            v = slot_val(es);
            exp_rd = wide ? (sw ? {v[7:0], v[15:8]} : v) : {8'h00, v[7:0]};
        end
        check((exp_req != 0 && sw) ? "R6" : tag, "acc_rdata", 32'(acc_rdata), 32'(exp_rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [24:0] a;
        repeat (3) @(negedge clk);
        // R10 reset state, sampled while reset is held
        check("R10", "slot_req in reset", 32'(slot_req), 32'(0));
        check("R10", "acc_done in reset", 32'(acc_done), 32'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R10", "ctrl_big_endian", 32'(ctrl_big_endian), 32'(0));
        check("R10", "slot_req after reset", 32'(slot_req), 32'(0));
        cfg_read_check(8'h2F, 8'h00, "R10");
        cfg_read_check(8'h33, 8'h00, "R10");

        // R7 configuration byte space
        cfg_write(8'h2B, 8'hFF);
        cfg_read_check(8'h2B, 8'h01, "R7");
        check("R7", "ctrl_big_endian", 32'(ctrl_big_endian), 32'(1));
        cfg_write(8'h2B, 8'hFE);
        cfg_read_check(8'h2B, 8'h00, "R7");
        cfg_write(8'h30, 8'h01);
        cfg_read_check(8'h30, 8'h00, "R7");
        cfg_read_check(8'h2F, 8'h00, "R7");
        cfg_read_check(8'h33, 8'h00, "R7");
        cfg_write(8'h2C, 8'hFF);
        cfg_read_check(8'h2C, 8'h00, "R7");
        check("R7", "ctrl_big_endian unaffected", 32'(ctrl_big_endian), 32'(0));

        for (int be = 0; be < 2; be++) begin
            cfg_write(8'h2F, 8'(be));
            cfg_write(8'h33, 8'(be));
            cfg_write(8'h2B, 8'(be));
            cfg_read_check(8'h2F, 8'(be), "R7");
            cfg_read_check(8'h33, 8'(be), "R7");
            check("R7", "ctrl_big_endian", 32'(ctrl_big_endian), 32'(be));
            slot_present = (be != 0) ? 4'b0111 : 4'b1011;
            for (int win = 0; win < 4; win++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int code = 0; code < 4; code++) begin
                        for (int wide = 0; wide < 2; wide++) begin
                            for (int wr = 0; wr < 2; wr++) begin
                                case (win)
                                    0: a = 25'((s << 8) | (code << 6) | 6'h2D | (wide << 1));
                                    1: a = 25'((s << 23) | ((code * 23'h1A5A5 + 23'h3C1 + wide) & 23'h7FFFFF));
                                    2: a = 25'(((code & 1) << 24) | (s << 22)
                                               | ((code * 22'h2F0F1 + 22'h117 + wide) & 22'h3FFFFF));
                                    default: a = 25'((s << 20) | code);
                                endcase
                                @(negedge clk);
                                do_access(win, wr[0], wide[0], a, be[0]);
                            end
                        end
                    end
                end
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule